// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem-control settings of a 16550-style serial port and reports the state of its four incoming handshake lines: clear-to-send, data-set-ready, carrier-detect and ring. The incoming lines pass through a synchroniser. The unit keeps a sticky change flag for each line. Any pending flag raises a modem-status interrupt request. A read of the status register returns the flags and then clears them.

In loopback mode the four control bits are routed internally onto the status inputs, so software can exercise the status path without any external wiring. The external outputs are held inactive and the external inputs are ignored while loopback is on. Access goes through plain write and read strobes with a one-bit register select. The register read data is combinational on the select.

Top module: `mdm_modem_ctl`

## Requirements
- R1: The control register (select 0) stores write-data bits 4:0 as loop=4, out2=3, out1=2, rts=1, dtr=0. A read returns these bits with bits 7:5 reading as zero.
- R2: After reset the control register reads 0x08 and the status register reads 0xB0. The interrupt request is low and only the out2 pin is high.
- R3: With loop=0, each output pin (pin_rts, pin_dtr, pin_out1, pin_out2; all active high) equals its control bit.
- R4: With loop=1, all four output pins are low.
- R5: The status register (select 1) has line states in bits 7:4 (carrier=7, ring=6, ready=5, clear=4). An external line change appears there on the third rising edge after it is applied, and not earlier.
- R6: Change flags for carrier (bit 3), ready (bit 1) and clear (bit 0) are set by a change in either direction. They stay set until a status read.
- R7: Ring flag bit 2 is set only when the ring line goes from 1 to 0. A rise of the ring line leaves it clear.
- R8: A status read returns the value present in that cycle. It then clears bits 3:0 at that clock edge.
- R9: msi_req is high exactly while any of status bits 3:0 is set.
- R10: With loop=1, the status line bits show carrier=out2, ring=out1, ready=dtr and clear=rts. Changes they cause set flags under R6 and R7.
- R11: With loop=1, the external line inputs have no effect on the status register.
- R12: A line change detected on the same edge as a status read leaves its new flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe (control register only) |
| reg_rd | input | 1 | Read strobe; a read of select 1 clears the change flags |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| line_cts | input | 1 | Clear-to-send input, asynchronous |
| line_dsr | input | 1 | Data-set-ready input, asynchronous |
| line_dcd | input | 1 | Carrier-detect input, asynchronous |
| line_ri | input | 1 | Ring input, asynchronous |
| pin_rts | output | 1 | Request-to-send output |
| pin_dtr | output | 1 | Data-terminal-ready output |
| pin_out1 | output | 1 | General output 1 |
| pin_out2 | output | 1 | General output 2 |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The bench drops a single line and checks the status register one edge before and on the edge where the change should land, which measures the synchroniser latency. It toggles a line away and back before a read, which separates a sticky flag from a live state comparison. It drives the ring line both ways to show that only the falling edge is flagged. It times a read onto the edge where a change lands, which tells whether the clear or the new flag wins. In loopback the bench writes several control patterns to confirm each mapped status bit. It also wiggles the external lines to show they are cut off.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int CTRL_W  = 5;
  localparam int LINES_W = 4;
  localparam int REG_W   = 8;
  // control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;
  // line nibble positions (status bits 7:4 / 3:0)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  localparam logic [CTRL_W-1:0]  CTRL_RST  = 5'b01000;
  localparam logic [LINES_W-1:0] LINES_RST = 4'b1011;
  typedef enum logic { SEL_CTRL = 1'b0, SEL_STAT = 1'b1 } reg_sel_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              pin_rts,
  output logic              pin_dtr,
  output logic              pin_out1,
  output logic              pin_out2
);
  logic wdata_unused;
  assign wdata_unused = ^wdata[REG_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= wdata[CTRL_W-1:0];
  end

  // outputs are parked low while looped back
  logic drive;
  assign drive    = ~ctrl_q[C_LOOP];
  assign pin_rts  = drive & ctrl_q[C_RTS];
  assign pin_dtr  = drive & ctrl_q[C_DTR];
  assign pin_out1 = drive & ctrl_q[C_OUT1];
  assign pin_out2 = drive & ctrl_q[C_OUT2];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES_W-1:0] ext_lines,
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic               rd_clr,
  output logic [LINES_W-1:0] lines_q,
  output logic [LINES_W-1:0] delta_q,
  output logic [LINES_W-1:0] evt
);
  logic [LINES_W-1:0] loop_lines, src;

  always_comb begin
    loop_lines        = '0;
    loop_lines[L_DCD] = ctrl[C_OUT2];
    loop_lines[L_RI]  = ctrl[C_OUT1];
    loop_lines[L_DSR] = ctrl[C_DTR];
    loop_lines[L_CTS] = ctrl[C_RTS];
  end

  assign src = ctrl[C_LOOP] ? loop_lines : ext_lines;

  generate
    for (genvar b = 0; b < LINES_W; b++) begin : g_evt
      if (b == L_RI) begin : g_trail
        assign evt[b] = lines_q[b] & ~src[b];
      end else begin : g_any
        assign evt[b] = lines_q[b] ^ src[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= LINES_RST;
      delta_q <= '0;
    end else begin
      lines_q <= src;
      delta_q <= (rd_clr ? '0 : delta_q) | evt;
    end
  end
endmodule

// File: rtl/mdm_modem_ctl.sv
module mdm_modem_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_dcd,
  input  logic       line_ri,
  output logic       pin_rts,
  output logic       pin_dtr,
  output logic       pin_out1,
  output logic       pin_out2,
  output logic       msi_req
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [LINES_W-1:0] raw_lines, ext_lines, lines_q, delta_q, evt;
  logic               rd_stat;

  assign raw_lines = {line_dcd, line_ri, line_dsr, line_cts};
  assign rd_stat   = reg_rd & (reg_sel == SEL_STAT);

  mdm_sync #(.W(LINES_W), .STAGES(SYNC_STAGES), .RST_VAL(LINES_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(ext_lines)
  );

  mdm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr & (reg_sel == SEL_CTRL)),
    .wdata(reg_wdata), .ctrl_q(ctrl_q),
    .pin_rts(pin_rts), .pin_dtr(pin_dtr), .pin_out1(pin_out1), .pin_out2(pin_out2)
  );

  mdm_status u_stat (
    .clk(clk), .rst_n(rst_n), .ext_lines(ext_lines), .ctrl(ctrl_q),
    .rd_clr(rd_stat), .lines_q(lines_q), .delta_q(delta_q), .evt(evt)
  );

  assign reg_rdata = (reg_sel == SEL_STAT) ? {lines_q, delta_q}
                                           : {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
  assign msi_req   = |delta_q;
endmodule

// File: rtl/mdm_modem_chk.sv
module mdm_modem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd,
  input logic       reg_sel,
  input logic [7:0] reg_rdata,
  input logic       pin_rts,
  input logic       pin_dtr,
  input logic       pin_out1,
  input logic       pin_out2,
  input logic       msi_req,
  input logic [4:0] ctrl_q,
  input logic [3:0] lines_q,
  input logic [3:0] delta_q,
  input logic [3:0] evt
);
  logic rd_stat;
  assign rd_stat = reg_rd & reg_sel;

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata[7:5] == 3'b000);

  a_r4_loop_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> !(pin_rts | pin_dtr | pin_out1 | pin_out2));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  a_r7_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[2]) |-> ($past(lines_q[2]) && !lines_q[2]));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && evt == 4'b0000) |=> !msi_req);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_req) |-> $past(evt != 4'b0000));
endmodule

bind mdm_modem_ctl mdm_modem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .pin_rts(pin_rts), .pin_dtr(pin_dtr),
  .pin_out1(pin_out1), .pin_out2(pin_out2), .msi_req(msi_req),
  .ctrl_q(ctrl_q), .lines_q(lines_q), .delta_q(delta_q), .evt(evt)
);

// File: tb/sim_mdm_modem_ctl.sv
`timescale 1ns/1ps
module sim_mdm_modem_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic line_cts = 1, line_dsr = 1, line_dcd = 1, line_ri = 0;
  logic pin_rts, pin_dtr, pin_out1, pin_out2, msi_req;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mdm_modem_ctl u0 (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    reg_sel = 0; reg_wdata = v; reg_wr = 1;
    tick(); reg_wr = 0;
  endtask

  task automatic peek(logic sel, output logic [7:0] v);
    reg_sel = sel; #1 v = reg_rdata;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    reg_sel = 1; reg_rd = 1; #1 v = reg_rdata;
    tick(); reg_rd = 0;
  endtask

  task automatic pins_check(string tag, logic [3:0] exp);
    check(tag, {4'b0, pin_out2, pin_out1, pin_rts, pin_dtr}, {4'b0, exp});
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(0, v); check("R2 ctrl reset", v, 8'h08);
    peek(1, v); check("R2 status reset", v, 8'hB0);
    check("R2 msi reset", {7'b0, msi_req}, 8'h00);
    pins_check("R2 pins reset", 4'b1000);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr_ctrl(8'hEF); peek(0, v); check("R1 upper bits zero", v, 8'h0F);
    pins_check("R3 all pins on", 4'b1111);
    wr_ctrl(8'h05); peek(0, v); check("R1 ctrl 0x05", v, 8'h05);
    pins_check("R3 dtr+out1", 4'b0101);
    peek(1, v); check("R3 no status effect", v, 8'hB0);
    wr_ctrl(8'h08);
  endtask

  task automatic t_lines();
    logic [7:0] v;
    line_cts = 0; tick(2);
    peek(1, v); check("R5 not before third edge", v, 8'hB0);
    tick(); peek(1, v); check("R5 R6 cts fall", v, 8'hA1);
    check("R9 msi set", {7'b0, msi_req}, 8'h01);
    rd_stat(v); check("R8 read value", v, 8'hA1);
    peek(1, v); check("R8 flags cleared", v, 8'hA0);
    check("R9 msi cleared", {7'b0, msi_req}, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    line_ri = 1; tick(3);
    peek(1, v); check("R7 ring rise no flag", v, 8'hE0);
    check("R7 R9 msi low on rise", {7'b0, msi_req}, 8'h00);
    line_ri = 0; tick(3);
    peek(1, v); check("R7 ring fall flag", v, 8'hA4);
    rd_stat(v); peek(1, v); check("R8 ring cleared", v, 8'hA0);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    line_dsr = 0; tick(3);
    line_dsr = 1; tick(3);
    peek(1, v); check("R6 dsr sticky after return", v, 8'hA2);
    rd_stat(v); check("R8 read sticky", v, 8'hA2);
    line_cts = 1; tick(3);
    peek(1, v); check("R6 cts rise flag", v, 8'hB1);
    rd_stat(v); peek(1, v); check("R8 back to idle", v, 8'hB0);
  endtask

  task automatic t_same_edge();
    logic [7:0] v;
    line_dcd = 0; tick(2);
    rd_stat(v); check("R12 read before change", v, 8'hB0);
    peek(1, v); check("R12 new flag kept", v, 8'h38);
    check("R12 msi kept", {7'b0, msi_req}, 8'h01);
    rd_stat(v); line_dcd = 1; tick(3);
    rd_stat(v); check("R6 dcd rise", v, 8'hB8);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr_ctrl(8'h10); pins_check("R4 pins idle", 4'b0000);
    tick(); peek(1, v); check("R10 loop all low", v, 8'h0B);
    rd_stat(v); peek(1, v); check("R8 loop clear", v, 8'h00);
    wr_ctrl(8'h1F); pins_check("R4 pins idle all set", 4'b0000);
    tick(); peek(1, v); check("R10 loop all high", v, 8'hFB);
    rd_stat(v);
    wr_ctrl(8'h1A); tick(); peek(1, v); check("R10 out2+rts map", v, 8'h96);
    rd_stat(v);
    line_cts = 0; line_dcd = 0; line_ri = 1; tick(5);
    peek(1, v); check("R11 external ignored", v, 8'h90);
    check("R11 msi low", {7'b0, msi_req}, 8'h00);
    line_cts = 1; line_dcd = 1; line_ri = 0; tick(3);
    wr_ctrl(8'h08); tick();
    peek(1, v); check("R10 exit loop dsr flag", v, 8'hB2);
    pins_check("R3 pins restored", 4'b1000);
  endtask

  initial begin
    tick(2); rst_n = 1; tick(1);
    t_reset(); t_ctrl(); t_lines(); t_ring(); t_sticky(); t_same_edge(); t_loop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule